// File: doc/BRIEF.md
# Peripheral Request Handshake Sequencer for a Buffered DMA Channel

This block paces one dual-address DMA channel from the peripheral side. It watches a request line from the peripheral and decides, each time it starts a bus operation, whether that operation loads the channel's staging buffer from the source or unloads it to the destination. The decision depends on how many bytes the buffer holds and how many bytes of the job are left. A datapath outside the block runs the actual bus cycles. It reports each finished operation with an acknowledge strobe or an error strobe, and it keeps the buffer level and the remaining-byte count up to date.

The block drives an acknowledge to the peripheral while the peripheral itself is being accessed. It drives a completion line during the operation that delivers the final bytes. The same completion line works as an input: the peripheral can use it to cut the job short. The request line can be read as a level or as a rising edge. An internal-request setting lets the channel run with no request at all once it has been started. In that setting the peripheral only receives the acknowledge.

Top module: `dreq_hs_ctrl`

## Requirements
- R1: After reset the channel is inactive, the error flag is clear, and bus_req_o, dack_o, done_o and done_oe_o are all low. A start pulse while the channel is inactive makes it active and clears the error flag.
- R2: In level mode a request line that is high before a rising edge is captured at that edge, and the operation it causes shows on bus_req_o after the next edge. Each captured high cycle counts as one request.
- R3: In edge mode only a low-to-high change of the captured request counts. A line held high starts exactly one operation.
- R4: In edge mode, rising edges that arrive while an operation is running are stored in one pending flag. However many there are, they release exactly one more operation.
- R5: On a request the block issues a write (bus_wr_o=1) of min(WR_BYTES, level) bytes when the level is at least WR_BYTES, or when the level is non-zero and equals the remaining count. Otherwise it issues a read (bus_wr_o=0) of min(RD_BYTES, remaining minus level) bytes.
- R6: When a read finishes and the buffer then holds at least max(RD_BYTES, WR_BYTES) bytes, or holds the entire remainder, a write starts with no request. Any later write waits for a new request.
- R7: bus_req_o stays high, with bus_wr_o and bus_len_o unchanged, until xfer_ta_i or xfer_tea_i. It is low in the cycle after the acknowledge.
- R8: dack_o is high only while an operation is running on the peripheral side. With per_is_src_i=0 that means writes, and with per_is_src_i=1 it means reads.
- R9: During a write whose length equals the remaining count, done_o and done_oe_o are both high. After its acknowledge the channel becomes inactive.
- R10: done_i high while dack_o is high and done_oe_o is low ends the operation at the next edge and makes the channel inactive. done_i has no effect while dack_o is low.
- R11: xfer_tea_i during an operation makes the channel inactive and sets err_o. err_o stays set until the next start pulse.
- R12: With int_mode_i=1 the channel starts operations back to back with no request input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for the channel |
| int_mode_i | input | 1 | 1 = run without requests |
| edge_mode_i | input | 1 | 1 = rising-edge requests, 0 = level requests |
| per_is_src_i | input | 1 | 1 = peripheral is the source, 0 = peripheral is the destination |
| dreq_i | input | 1 | Peripheral request line |
| done_i | input | 1 | Completion line, input side |
| done_o | output | 1 | Completion line, output value |
| done_oe_o | output | 1 | Completion line, output enable |
| dack_o | output | 1 | Acknowledge to the peripheral |
| buf_level_i | input | LVL_W | Bytes held in the staging buffer |
| rem_cnt_i | input | CNT_W | Bytes of the job not yet written to the destination |
| bus_req_o | output | 1 | A bus operation is running |
| bus_wr_o | output | 1 | 1 = buffer unload, 0 = buffer load |
| bus_len_o | output | CNT_W | Byte length of the operation |
| xfer_ta_i | input | 1 | The operation finished normally |
| xfer_tea_i | input | 1 | The operation finished with an error |
| active_o | output | 1 | The channel is running |
| err_o | output | 1 | Sticky error flag |

## Verification
The assertions assume that the datapath raises xfer_ta_i or xfer_tea_i only while bus_req_o is high. They also assume that it never reports a level above the remaining count, so a read can never have zero length. The bench acts as that datapath. It raises each strobe for exactly one cycle, only after it has seen bus_req_o, and it sets the level and the remaining count in that same cycle, keeping the level at or below the remainder.

// File: rtl/dreq_hs_pkg.sv
package dreq_hs_pkg;
   typedef enum logic [1:0] {
      CH_OFF  = 2'd0,
      CH_IDLE = 2'd1,
      CH_XFER = 2'd2
   } ch_state_e;
endpackage

// File: rtl/dreq_hs_sense.sv
module dreq_hs_sense #(
   parameter int IN_FLOPS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic edge_mode,
   input  logic dreq_raw,
   input  logic take,
   output logic req
);
   logic [IN_FLOPS-1:0] cap_q;
   logic                samp;
   logic                prev_q;
   logic                rise;
   logic                pend_q;
   logic                pend_d;

   generate
      if (IN_FLOPS == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cap_q <= '0;
            else        cap_q <= dreq_raw;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cap_q <= '0;
            else        cap_q <= {cap_q[IN_FLOPS-2:0], dreq_raw};
         end
      end
   endgenerate

   assign samp = cap_q[IN_FLOPS-1];
   assign rise = samp & ~prev_q;

   always_comb begin
      if (!en || !edge_mode) pend_d = 1'b0;
      else if (take)         pend_d = pend_q & rise;
      else                   pend_d = pend_q | rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= samp;
         pend_q <= pend_d;
      end
   end

   assign req = edge_mode ? (pend_q | rise) : samp;
endmodule

// File: rtl/dreq_hs_opsel.sv
module dreq_hs_opsel #(
   parameter int RD_BYTES = 96,
   parameter int WR_BYTES = 32,
   parameter int LVL_W    = 8,
   parameter int CNT_W    = 16
) (
   input  logic [LVL_W-1:0] level,
   input  logic [CNT_W-1:0] rem,
   output logic             want_wr,
   output logic             auto_ok,
   output logic [CNT_W-1:0] rd_len,
   output logic [CNT_W-1:0] wr_len,
   output logic             wr_last
);
   localparam int FULL_BYTES = (RD_BYTES > WR_BYTES) ? RD_BYTES : WR_BYTES;
   localparam logic [CNT_W-1:0] RD_C   = CNT_W'(RD_BYTES);
   localparam logic [CNT_W-1:0] WR_C   = CNT_W'(WR_BYTES);
   localparam logic [CNT_W-1:0] FULL_C = CNT_W'(FULL_BYTES);

   logic [CNT_W-1:0] lvl_x;
   logic [CNT_W-1:0] room;
   logic             all_in;

   assign lvl_x  = CNT_W'(level);
   assign room   = (rem > lvl_x) ? (rem - lvl_x) : '0;
   assign all_in = (lvl_x != '0) && (lvl_x == rem);

   assign want_wr = (lvl_x >= WR_C) || all_in;
   assign auto_ok = (lvl_x >= FULL_C) || all_in;
   assign rd_len  = (room < RD_C) ? room : RD_C;
   assign wr_len  = (lvl_x < WR_C) ? lvl_x : WR_C;
   assign wr_last = (wr_len == rem) && (rem != '0);
endmodule

// File: rtl/dreq_hs_fsm.sv
module dreq_hs_fsm
   import dreq_hs_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             int_mode,
   input  logic             req,
   input  logic             want_wr,
   input  logic             auto_ok,
   input  logic [CNT_W-1:0] rd_len,
   input  logic [CNT_W-1:0] wr_len,
   input  logic             wr_last,
   input  logic [CNT_W-1:0] rem,
   input  logic             ta,
   input  logic             tea,
   input  logic             abort,
   output ch_state_e        state,
   output logic             op_wr,
   output logic [CNT_W-1:0] op_len,
   output logic             op_last,
   output logic             take,
   output logic             err
);
   ch_state_e        st_d;
   logic             wr_d, last_d, auto_q, auto_d, err_d;
   logic [CNT_W-1:0] len_d;
   logic             go_auto, go_req;

   assign go_auto = (state == CH_IDLE) && (rem != '0) && auto_q && auto_ok;
   assign go_req  = (state == CH_IDLE) && (rem != '0) && !auto_q && (req || int_mode);
   assign take    = go_req && !int_mode;

   always_comb begin
      st_d   = state;
      wr_d   = op_wr;
      len_d  = op_len;
      last_d = op_last;
      auto_d = auto_q;
      err_d  = err;
      unique case (state)
         CH_OFF: begin
            if (start) begin
               st_d   = CH_IDLE;
               err_d  = 1'b0;
               auto_d = 1'b0;
            end
         end
         CH_IDLE: begin
            if (rem == '0) begin
               st_d = CH_OFF;
            end else if (auto_q) begin
               auto_d = 1'b0;
               if (go_auto) begin
                  st_d   = CH_XFER;
                  wr_d   = 1'b1;
                  len_d  = wr_len;
                  last_d = wr_last;
               end
            end else if (go_req) begin
               st_d   = CH_XFER;
               wr_d   = want_wr;
               len_d  = want_wr ? wr_len : rd_len;
               last_d = want_wr && wr_last;
            end
         end
         CH_XFER: begin
            if (tea) begin
               st_d  = CH_OFF;
               err_d = 1'b1;
            end else if (abort) begin
               st_d = CH_OFF;
            end else if (ta) begin
               st_d   = op_last ? CH_OFF : CH_IDLE;
               auto_d = !op_wr;
            end
         end
         default: st_d = CH_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= CH_OFF;
         op_wr   <= 1'b0;
         op_len  <= '0;
         op_last <= 1'b0;
         auto_q  <= 1'b0;
         err     <= 1'b0;
      end else begin
         state   <= st_d;
         op_wr   <= wr_d;
         op_len  <= len_d;
         op_last <= last_d;
         auto_q  <= auto_d;
         err     <= err_d;
      end
   end
endmodule

// File: rtl/dreq_hs_ctrl.sv
module dreq_hs_ctrl
   import dreq_hs_pkg::*;
#(
   parameter int RD_BYTES = 96,
   parameter int WR_BYTES = 32,
   parameter int BURST    = 32,
   parameter int LVL_W    = 8,
   parameter int CNT_W    = 16,
   parameter int IN_FLOPS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             int_mode_i,
   input  logic             edge_mode_i,
   input  logic             per_is_src_i,
   input  logic             dreq_i,
   input  logic             done_i,
   output logic             done_o,
   output logic             done_oe_o,
   output logic             dack_o,
   input  logic [LVL_W-1:0] buf_level_i,
   input  logic [CNT_W-1:0] rem_cnt_i,
   output logic             bus_req_o,
   output logic             bus_wr_o,
   output logic [CNT_W-1:0] bus_len_o,
   input  logic             xfer_ta_i,
   input  logic             xfer_tea_i,
   output logic             active_o,
   output logic             err_o
);
   localparam int FULL_BYTES = (RD_BYTES > WR_BYTES) ? RD_BYTES : WR_BYTES;

   generate
      if (RD_BYTES % BURST != 0 || WR_BYTES % BURST != 0) begin : g_bad_burst
         $error("transfer sizes must be whole bursts");
      end
      if (FULL_BYTES % RD_BYTES != 0 || FULL_BYTES % WR_BYTES != 0) begin : g_bad_div
         $error("transfer sizes must divide the buffer size");
      end
      if (FULL_BYTES >= (1 << LVL_W)) begin : g_bad_lvl
         $error("level width too small for the buffer");
      end
      if (IN_FLOPS < 1) begin : g_bad_flops
         $error("at least one capture flop is needed");
      end
   endgenerate

   ch_state_e        state;
   logic             req, take;
   logic             want_wr, auto_ok, wr_last;
   logic [CNT_W-1:0] rd_len, wr_len;
   logic             op_wr, op_last;
   logic [CNT_W-1:0] op_len;
   logic             running, per_side, abort;

   dreq_hs_sense #(.IN_FLOPS(IN_FLOPS)) u_sense (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (state != CH_OFF),
      .edge_mode (edge_mode_i),
      .dreq_raw  (dreq_i),
      .take      (take),
      .req       (req)
   );

   dreq_hs_opsel #(
      .RD_BYTES (RD_BYTES),
      .WR_BYTES (WR_BYTES),
      .LVL_W    (LVL_W),
      .CNT_W    (CNT_W)
   ) u_opsel (
      .level   (buf_level_i),
      .rem     (rem_cnt_i),
      .want_wr (want_wr),
      .auto_ok (auto_ok),
      .rd_len  (rd_len),
      .wr_len  (wr_len),
      .wr_last (wr_last)
   );

   dreq_hs_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_i),
      .int_mode (int_mode_i),
      .req      (req),
      .want_wr  (want_wr),
      .auto_ok  (auto_ok),
      .rd_len   (rd_len),
      .wr_len   (wr_len),
      .wr_last  (wr_last),
      .rem      (rem_cnt_i),
      .ta       (xfer_ta_i),
      .tea      (xfer_tea_i),
      .abort    (abort),
      .state    (state),
      .op_wr    (op_wr),
      .op_len   (op_len),
      .op_last  (op_last),
      .take     (take),
      .err      (err_o)
   );

   assign running   = (state == CH_XFER);
   assign per_side  = op_wr ^ per_is_src_i;
   assign dack_o    = running && per_side;
   assign done_o    = running && op_last;
   assign done_oe_o = running && op_last;
   assign abort     = done_i && dack_o && !done_oe_o;
   assign bus_req_o = running;
   assign bus_wr_o  = op_wr;
   assign bus_len_o = op_len;
   assign active_o  = (state != CH_OFF);
endmodule

// File: rtl/dreq_hs_ctrl_chk.sv
module dreq_hs_ctrl_chk #(
   parameter int WR_BYTES = 32,
   parameter int RD_BYTES = 96,
   parameter int CNT_W    = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done_i,
   input logic             done_o,
   input logic             done_oe_o,
   input logic             dack_o,
   input logic             bus_req_o,
   input logic             bus_wr_o,
   input logic [CNT_W-1:0] bus_len_o,
   input logic             xfer_ta_i,
   input logic             xfer_tea_i,
   input logic             active_o,
   input logic             err_o
);
   // R8
   dack_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dack_o |-> bus_req_o);

   // R9
   done_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_oe_o |-> (bus_req_o && bus_wr_o && done_o));

   // R7
   op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !xfer_ta_i && !xfer_tea_i && !(done_i && dack_o && !done_oe_o))
      |=> (bus_req_o && $stable(bus_wr_o) && $stable(bus_len_o)));

   // R7
   op_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && xfer_ta_i) |=> !bus_req_o);

   // R11
   tea_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && xfer_tea_i) |=> (!active_o && err_o));

   // R10
   done_in_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && done_i && dack_o && !done_oe_o && !xfer_tea_i) |=> (!active_o && !bus_req_o));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_o |-> (!bus_req_o && !dack_o && !done_oe_o));

   // R5
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o |-> (bus_wr_o ? (bus_len_o <= CNT_W'(WR_BYTES)) : (bus_len_o <= CNT_W'(RD_BYTES))));
endmodule

bind dreq_hs_ctrl dreq_hs_ctrl_chk #(
   .WR_BYTES (WR_BYTES),
   .RD_BYTES (RD_BYTES),
   .CNT_W    (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .done_i     (done_i),
   .done_o     (done_o),
   .done_oe_o  (done_oe_o),
   .dack_o     (dack_o),
   .bus_req_o  (bus_req_o),
   .bus_wr_o   (bus_wr_o),
   .bus_len_o  (bus_len_o),
   .xfer_ta_i  (xfer_ta_i),
   .xfer_tea_i (xfer_tea_i),
   .active_o   (active_o),
   .err_o      (err_o)
);

// File: tb/dreq_hs_ctrl_bench.sv
module dreq_hs_ctrl_bench;
   localparam int CLK_NS = 10;
   localparam int LVL_W  = 8;
   localparam int CNT_W  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 0, int_mode_i = 0, edge_mode_i = 0, per_is_src_i = 0;
   logic dreq_i = 0, done_i = 0, xfer_ta_i = 0, xfer_tea_i = 0;
   logic done_o, done_oe_o, dack_o, bus_req_o, bus_wr_o, active_o, err_o;
   logic [LVL_W-1:0] buf_level_i = '0;
   logic [CNT_W-1:0] rem_cnt_i = '0;
   logic [CNT_W-1:0] bus_len_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #(CLK_NS/2) clk = ~clk;

   dreq_hs_ctrl u_dreq_hs_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .int_mode_i(int_mode_i),
      .edge_mode_i(edge_mode_i), .per_is_src_i(per_is_src_i), .dreq_i(dreq_i),
      .done_i(done_i), .done_o(done_o), .done_oe_o(done_oe_o), .dack_o(dack_o),
      .buf_level_i(buf_level_i), .rem_cnt_i(rem_cnt_i), .bus_req_o(bus_req_o),
      .bus_wr_o(bus_wr_o), .bus_len_o(bus_len_o), .xfer_ta_i(xfer_ta_i),
      .xfer_tea_i(xfer_tea_i), .active_o(active_o), .err_o(err_o)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic start_ch(bit im, bit em, bit src, int lvl, int rem);
      int_mode_i = im; edge_mode_i = em; per_is_src_i = src;
      buf_level_i = LVL_W'(lvl); rem_cnt_i = CNT_W'(rem);
      start_i = 1; tick(); start_i = 0; tick();
   endtask

   // wait for an operation, then check its kind, length, acknowledge and completion line
   task automatic expect_op(string tag, bit wr, int len, bit dk, bit dn);
      int w = 0;
      while (!bus_req_o && w < 10) begin tick(); w++; end
      chk({tag, " bus_req"}, bus_req_o, 1);
      chk({tag, " bus_wr"}, bus_wr_o, wr);
      chk({tag, " bus_len"}, bus_len_o, len);
      chk({tag, " dack"}, dack_o, dk);
      chk({tag, " done_oe"}, done_oe_o & done_o, dn);
   endtask

   task automatic finish_op(string tag, int lvl, int rem);
      xfer_ta_i = 1; buf_level_i = LVL_W'(lvl); rem_cnt_i = CNT_W'(rem);
      tick(); xfer_ta_i = 0;
      chk({tag, " bus_req drops"}, bus_req_o, 0);
   endtask

   task automatic stay_quiet(string tag, int n);
      bit seen = 0;
      for (int i = 0; i < n; i++) begin tick(); if (bus_req_o) seen = 1; end
      chk({tag, " no operation"}, seen, 0);
   endtask

   task automatic pulse_req();
      dreq_i = 1; tick(); dreq_i = 0;
   endtask

   task automatic t_reset();
      chk("R1 reset active", active_o, 0);
      chk("R1 reset err", err_o, 0);
      chk("R1 reset outputs", {bus_req_o, dack_o, done_o, done_oe_o}, 0);
   endtask

   task automatic t_level_m2p();
      start_ch(0, 0, 0, 0, 200);
      chk("R1 start active", active_o, 1);
      dreq_i = 1; tick();
      chk("R2 not yet", bus_req_o, 0);
      tick();
      chk("R2 launched", bus_req_o, 1);
      dreq_i = 0;
      expect_op("R5 first read", 0, 96, 0, 0);
      for (int i = 0; i < 3; i++) tick();
      expect_op("R7 held", 0, 96, 0, 0);
      finish_op("R7", 96, 200);
      expect_op("R6 auto write", 1, 32, 1, 0);
      finish_op("R8", 64, 168);
      stay_quiet("R6 next write waits", 5);
      pulse_req();
      expect_op("R5 write on request", 1, 32, 1, 0);
      finish_op("R5", 10, 50);
      pulse_req();
      expect_op("R5 read clamp", 0, 40, 0, 0);
      finish_op("R5", 20, 20);
      expect_op("R9 final via auto", 1, 20, 1, 1);
      finish_op("R9", 0, 0);
      tick();
      chk("R9 inactive after last", active_o, 0);
   endtask

   task automatic t_edge_p2m();
      start_ch(0, 1, 1, 0, 1000);
      dreq_i = 1;
      expect_op("R3 read from peripheral", 0, 96, 1, 0);
      finish_op("R3", 96, 1000);
      expect_op("R8 auto write to memory", 1, 32, 0, 0);
      dreq_i = 0; tick(); dreq_i = 1; tick(); tick();
      dreq_i = 0; tick(); dreq_i = 1; tick(); tick();
      finish_op("R4", 64, 968);
      expect_op("R4 one queued write", 1, 32, 0, 0);
      finish_op("R4", 32, 936);
      stay_quiet("R4 only one queued R3 held high", 6);
      dreq_i = 0;
      start_i = 0;
   endtask

   task automatic t_done_in();
      rst_n = 0; tick(); rst_n = 1; tick();
      start_ch(0, 0, 0, 0, 500);
      pulse_req();
      expect_op("R10 read", 0, 96, 0, 0);
      done_i = 1; tick();
      chk("R10 ignored without dack", bus_req_o, 1);
      done_i = 0;
      finish_op("R10", 96, 500);
      expect_op("R10 write", 1, 32, 1, 0);
      done_i = 1; tick(); done_i = 0;
      chk("R10 op ended", bus_req_o, 0);
      chk("R10 channel stopped", active_o, 0);
      pulse_req();
      stay_quiet("R10 no more", 4);
   endtask

   task automatic t_tea();
      start_ch(0, 0, 0, 0, 300);
      pulse_req();
      expect_op("R11 read", 0, 96, 0, 0);
      xfer_tea_i = 1; tick(); xfer_tea_i = 0;
      chk("R11 stopped", active_o, 0);
      chk("R11 err set", err_o, 1);
      pulse_req();
      stay_quiet("R11 no more", 4);
      chk("R11 err sticky", err_o, 1);
      start_ch(0, 0, 0, 0, 300);
      chk("R1 start clears err", err_o, 0);
      rst_n = 0; tick(); rst_n = 1; tick();
   endtask

   task automatic t_internal();
      start_ch(1, 0, 0, 0, 128);
      expect_op("R12 read", 0, 96, 0, 0);
      finish_op("R12", 96, 128);
      expect_op("R12 auto write", 1, 32, 1, 0);
      finish_op("R12", 64, 96);
      expect_op("R12 write no request", 1, 32, 1, 0);
      finish_op("R12", 32, 64);
      expect_op("R12 again", 1, 32, 1, 0);
      finish_op("R12", 0, 32);
      expect_op("R12 tail read", 0, 32, 0, 0);
      finish_op("R12", 32, 32);
      expect_op("R9 last", 1, 32, 1, 1);
      finish_op("R9", 0, 0);
      tick();
      chk("R9 ends", active_o, 0);
   endtask

   initial begin
      for (int i = 0; i < 20000; i++) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      t_reset();
      rst_n = 1; tick();
      t_reset();
      t_level_m2p();
      t_edge_p2m();
      t_done_in();
      t_tea();
      t_internal();
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule